// File: doc/BRIEF.md
# Dual DAC Update and Coding Controller

This block sits between a simple host write bus and two 12-bit DAC output latches. The host writes a 4-bit mode command and two 12-bit data words. For each channel, the command chooses one of two update modes. In immediate mode, a data write reaches the latch on the next clock. In paced mode, the write lands in a staging register, and the latch copies that register on each update event.

An update event has two sources, and they are combined by OR. One is an internal 16-bit reload down-counter. The other is the falling edge of an active-low external pin, taken through a two-flop synchronizer. The command also picks the input coding for each channel separately. When a channel's data is two's complement, its most significant bit is inverted as the value enters the latch, so the latch always holds straight binary.

Reset is asynchronous and active-low, and its release is synchronized inside the block. The host uses a single write strobe with a 2-bit word address. There is no read path.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, both outputs are 0 and the command is 0: both channels are in immediate mode with straight binary coding.
- R2: Address map for host writes:
  - Address 1 loads the command from wr_data[7:4].
  - Bit 7 makes DAC1 paced and bit 6 makes DAC0 paced.
  - Bit 5 makes DAC1 data two's complement and bit 4 does the same for DAC0.
  - wr_data bits 3:0 and 11:8 have no effect on a command write.
  - Address 2 writes DAC0 data and address 3 writes DAC1 data, using wr_data[11:0].
- R3: In immediate mode, a data write shows on that channel's output on the clock edge that accepts the write.
- R4: In paced mode, a data write leaves the output unchanged. The output takes the staged value at the first update event after the write.
- R5: In paced mode, an update event with no new write reloads the same staged value, so the output does not change.
- R6: With two's complement coding selected, the output equals the data with bit 11 inverted. With straight binary coding, the output equals the data.
- R7: The internal counter flags an event on upd_evt in every cycle where its count is 0, and then reloads from interval. This gives one event every interval+1 cycles, and the first one comes while reset is still held.
- R8: A falling edge on ext_upd_n gives exactly one event cycle. That cycle is the second cycle after the clock edge that first samples the pin low. Holding the pin low gives no further events.
- R9: The two channels are independent. Mode, coding and writes for one channel never change the other channel's output.
- R10: A write to address 0 changes neither output nor the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host word address |
| wr_data | input | 12 | Host write data |
| ext_upd_n | input | 1 | Asynchronous active-low external update request |
| interval | input | 16 | Reload value of the pacing counter |
| upd_evt | output | 1 | Update event, one cycle wide |
| dac0_out | output | 12 | DAC0 output latch, straight binary |
| dac1_out | output | 12 | DAC1 output latch, straight binary |

## Verification
The assertions check four things on every cycle:
- an immediate-mode write reaches the latch on the next edge, with its low bits intact;
- when two's complement is selected, the top bit comes out inverted;
- a paced latch stays put in any cycle without an event;
- the counter pulse and the external-pin event each last a single cycle.

The bench covers what only a sequence of cycles can show:
- the exact cycle when a staged value appears after a pin edge or a counter pulse;
- the reload of an unchanged staged value;
- the effect of the reserved and unused address bits;
- the independence of the two channels under mixed modes.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned AW = 2;

  localparam logic [AW-1:0] ADDR_NONE = 2'd0;
  localparam logic [AW-1:0] ADDR_CMD  = 2'd1;
  localparam logic [AW-1:0] ADDR_CH0  = 2'd2;
  localparam logic [AW-1:0] ADDR_CH1  = 2'd3;

  // Command fields, ordered to match host bits 7..4.
  typedef struct packed {
    logic paced1;
    logic paced0;
    logic twos1;
    logic twos0;
  } mode_cmd_t;
endpackage

// File: rtl/dac_interval_ctr.sv
module dac_interval_ctr #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] reload_i,
  output logic          pulse_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    pulse_o = (cnt_q == '0);
    cnt_d   = pulse_o ? reload_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && reload_i != '0) |=> !pulse_o); // R7
endmodule

// File: rtl/dac_ext_sync.sv
module dac_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n_i,
  output logic evt_o
);
  logic [STAGES:0] sync_q, sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-1:0], pin_n_i};
    evt_o  = sync_q[STAGES] & ~sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  AST_EXT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o); // R8
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          paced_i,
  input  logic          twos_i,
  input  logic          upd_i,
  output logic [DW-1:0] out_o
);
  logic [DW-1:0] stage_q, stage_d, out_q, out_d;
  logic          stage_en, out_en;

  function automatic logic [DW-1:0] to_offset(input logic [DW-1:0] v, input logic twos);
    return {v[DW-1] ^ twos, v[DW-2:0]};
  endfunction

  always_comb begin
    stage_en = wr_i;
    stage_d  = wdata_i;
    out_en   = 1'b0;
    out_d    = out_q;
    if (!paced_i && wr_i) begin
      out_en = 1'b1;
      out_d  = to_offset(wdata_i, twos_i);
    end else if (paced_i && upd_i) begin
      out_en = 1'b1;
      out_d  = to_offset(stage_q, twos_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_d;
      if (out_en)   out_q   <= out_d;
    end
  end

  assign out_o = out_q;

  AST_IMMEDIATE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!paced_i && wr_i) |=> (out_q[DW-2:0] == $past(wdata_i[DW-2:0]))); // R3
  AST_TWOS_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (!paced_i && wr_i && twos_i) |=> (out_q[DW-1] != $past(wdata_i[DW-1]))); // R6
  AST_PACED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (paced_i && !upd_i) |=> $stable(out_q)); // R4
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl #(
  parameter int unsigned DW = 12,
  parameter int unsigned CW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [dac_pkg::AW-1:0]  wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ext_upd_n,
  input  logic [CW-1:0]           interval,
  output logic                    upd_evt,
  output logic [DW-1:0]           dac0_out,
  output logic [DW-1:0]           dac1_out
);
  import dac_pkg::*;
  localparam int unsigned NCH = 2;

  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  mode_cmd_t cmd_q, cmd_d;
  logic      cmd_en;

  always_comb begin
    cmd_en = wr_en && (wr_addr == ADDR_CMD);
    cmd_d  = mode_cmd_t'(wr_data[7:4]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cmd_q <= '0;
    else if (cmd_en) cmd_q <= cmd_d;
  end

  logic ctr_pulse, ext_evt;

  dac_interval_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_int_n), .reload_i(interval), .pulse_o(ctr_pulse));

  dac_ext_sync #(.STAGES(2)) u_ext (
    .clk(clk), .rst_n(rst_int_n), .pin_n_i(ext_upd_n), .evt_o(ext_evt));

  assign upd_evt = ctr_pulse | ext_evt;

  logic [NCH-1:0] paced_v, twos_v, wr_v;
  logic [DW-1:0]  out_v [NCH];

  assign paced_v = {cmd_q.paced1, cmd_q.paced0};
  assign twos_v  = {cmd_q.twos1, cmd_q.twos0};
  assign wr_v    = {wr_en && (wr_addr == ADDR_CH1), wr_en && (wr_addr == ADDR_CH0)};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_int_n), .wr_i(wr_v[ch]), .wdata_i(wr_data),
      .paced_i(paced_v[ch]), .twos_i(twos_v[ch]), .upd_i(upd_evt),
      .out_o(out_v[ch]));
  end

  assign dac0_out = out_v[0];
  assign dac1_out = out_v[1];

  AST_CH1_ISOLATED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr != ADDR_CH1 && !(paced_v[1] && upd_evt)) |=> $stable(dac1_out)); // R9
endmodule

// File: tb/sim_dac_update_ctrl.sv
module sim_dac_update_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        ext_upd_n = 1'b1;
  logic [15:0] interval = 16'hFFFF;
  logic        upd_evt;
  logic [11:0] dac0_out, dac1_out;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  dac_update_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ext_upd_n(ext_upd_n), .interval(interval), .upd_evt(upd_evt),
    .dac0_out(dac0_out), .dac1_out(dac1_out));

  // Behavioural reference model
  int   m_cnt;
  bit   m_rs1, m_rs2, m_p1, m_p2, m_p3;
  bit   m_paced[2], m_twos[2];
  int   m_stage[2], m_out[2];

  function automatic int code(int v, bit twos);
    return twos ? (v ^ 12'h800) : v;
  endfunction

  function automatic bit m_evt();
    return (m_cnt == 0) || (m_p3 && !m_p2);
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_p1 = 1; m_p2 = 1; m_p3 = 1;
    for (int i = 0; i < 2; i++) begin
      m_paced[i] = 0; m_twos[i] = 0; m_stage[i] = 0; m_out[i] = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs1 = 0; m_rs2 = 0; m_reset();
    end else begin
      if (m_rs2) begin
        bit ev;
        ev = m_evt();
        for (int i = 0; i < 2; i++) begin
          bit hit;
          hit = wr_en && (int'(wr_addr) == i + 2);
          if (!m_paced[i] && hit)    m_out[i] = code(int'(wr_data), m_twos[i]);
          else if (m_paced[i] && ev) m_out[i] = code(m_stage[i], m_twos[i]);
          if (hit) m_stage[i] = int'(wr_data);
        end
        if (wr_en && wr_addr == 2'd1) begin
          m_paced[1] = wr_data[7]; m_paced[0] = wr_data[6];
          m_twos[1]  = wr_data[5]; m_twos[0]  = wr_data[4];
        end
        m_cnt = (m_cnt == 0) ? int'(interval) : m_cnt - 1;
        m_p3 = m_p2; m_p2 = m_p1; m_p1 = ext_upd_n;
      end
      m_rs2 = m_rs1; m_rs1 = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    chk(cur_req, int'(dac0_out), m_out[0]);
    chk(cur_req, int'(dac1_out), m_out[1]);
    chk(cur_req, int'(upd_evt), int'(m_evt()));
  end

  task automatic wr(logic [1:0] a, logic [11:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  int ev_cnt;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    chk("R1", int'(dac0_out), 0); chk("R1", int'(dac1_out), 0);
    rst_n = 1;
    idle(4);
    chk("R1", int'(dac0_out), 0);

    cur_req = "R3";
    wr(2'd2, 12'h123); chk("R3", int'(dac0_out), 12'h123);
    wr(2'd3, 12'hABC); chk("R3", int'(dac1_out), 12'hABC);

    cur_req = "R6";
    wr(2'd1, 12'h030);
    wr(2'd2, 12'h800); chk("R6", int'(dac0_out), 12'h000);
    wr(2'd3, 12'h7FF); chk("R6", int'(dac1_out), 12'hFFF);

    cur_req = "R10";
    wr(2'd0, 12'h0C0);
    wr(2'd2, 12'h456); chk("R10", int'(dac0_out), 12'hC56);
    chk("R10", int'(dac1_out), 12'hFFF);

    cur_req = "R2";
    wr(2'd1, 12'hF0F);
    wr(2'd3, 12'h0F0); chk("R2", int'(dac1_out), 12'h0F0);
    wr(2'd2, 12'h321); chk("R2", int'(dac0_out), 12'h321);

    cur_req = "R4";
    wr(2'd1, 12'h080);
    wr(2'd3, 12'h555);
    idle(10); chk("R4", int'(dac1_out), 12'h0F0);
    cur_req = "R9";
    wr(2'd2, 12'h111); chk("R9", int'(dac0_out), 12'h111);
    chk("R9", int'(dac1_out), 12'h0F0);
    cur_req = "R8";
    ev_cnt = 0;
    @(negedge clk); ext_upd_n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (upd_evt) ev_cnt++;
      if (i == 1) chk("R8", int'(upd_evt), 1);
    end
    chk("R8", ev_cnt, 1);
    chk("R4", int'(dac1_out), 12'h555);
    ext_upd_n = 1;
    idle(4);

    cur_req = "R5";
    @(negedge clk); ext_upd_n = 0; idle(5); ext_upd_n = 1;
    chk("R5", int'(dac1_out), 12'h555);
    wr(2'd1, 12'h0A0);
    wr(2'd3, 12'h200); chk("R5", int'(dac1_out), 12'h555);
    @(negedge clk); ext_upd_n = 0; idle(5); ext_upd_n = 1;
    chk("R6", int'(dac1_out), 12'hA00);
    idle(4);

    cur_req = "R7";
    wr(2'd1, 12'h0C0);
    interval = 16'd7;
    idle(70000);
    ev_cnt = 0;
    wr(2'd2, 12'h777);
    wr(2'd3, 12'h999);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (upd_evt) ev_cnt++;
    end
    chk("R7", ev_cnt, 5);
    chk("R7", int'(dac0_out), 12'h777);
    chk("R7", int'(dac1_out), 12'h999);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule